// File: doc/BRIEF.md
# Serial Peripheral Master Transfer Engine

This block is the bit-level engine behind a serial peripheral (SPI) master port. A parallel transmit word enters through a valid/ready handshake into a one-word holding stage. The engine takes each held word, drives it onto the serial data-out line most significant bit first, and collects the same number of bits from the data-in line. When a frame ends it presents the received word with a one-cycle valid pulse. The register file, the FIFOs and slave operation sit outside the block and reach it only through these word-level signals.

The serial clock is derived from the system clock. A 2-bit select field and a period value set the divide ratio. Clock polarity and phase are set by separate inputs. A frame carries 8, 16, 32 or 9 bits. In the 9-bit case the first bit sent is a separately configured constant. While no frame is running, data-out holds a programmable level, and a force input holds it at that level during frames as well. A two-stage synchronised copy of the raw data-in pin is also brought out. Clearing the enable input stops new words from being accepted. It does not cut off the frame in flight or the word already held: both are sent, and the engine then stays idle.

Top module: `spi_master_engine`

## Requirements
- R1: `word_mode` selects the frame length: 2'b00 gives 8 bits, 2'b01 gives 16 bits, 2'b10 gives 32 bits and 2'b11 gives 9 bits. The transmit word is sent most significant bit first, using its low 8, low 16 or all 32 bits.
- R2: In a 9-bit frame the first bit on `mosi` is `nine_first`, followed by `tx_data[7:0]` from bit 7 down to bit 0.
- R3: Each half period of `sclk` lasts P*M system clocks. P is `period`, and M is 4, 2, 1 or 7 for `clk_sel` 2'b00, 2'b01, 2'b10 or 2'b11. The full serial clock period is therefore P times 8, 4, 2 or 14.
- R4: While no frame is running, `sclk` rests at `cpol`. Every frame starts and ends at that level.
- R5: With `cpha` = 0, the first data bit is on `mosi` before the first `sclk` edge. `miso` is sampled on the leading edge of each bit and `mosi` changes on the trailing edge. With `cpha` = 1, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge.
- R6: `mosi` equals `idle_level` whenever no frame is running, and for the whole of any frame that runs with `force_out` = 1.
- R7: `din_sync` equals the value `miso` had two system clock edges earlier.
- R8: On `rx_valid`, a 32-bit frame replaces all of `rx_data`. A 16-bit frame replaces bits 15:0 only. An 8-bit frame, or the last 8 bits of a 9-bit frame, replaces bits 7:0 only. Bits that are not replaced keep their earlier contents, and the first received bit of a 9-bit frame is dropped.
- R9: While `enable` is 0, `tx_ready` is 0. A frame already running and a word already held are both still sent, after which `busy` falls and stays low.
- R10: `rx_valid` is a single-cycle pulse after the final half period of each frame. `busy` is high from the cycle after a word is accepted until the frame built from it has ended.
- R11: A `period` of zero behaves exactly like a `period` of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new words to be accepted |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Sampling edge choice |
| clk_sel | input | 2 | Divide-ratio select |
| period | input | PERIOD_W | Divider period value |
| word_mode | input | 2 | Frame length select |
| nine_first | input | 1 | First bit of a 9-bit frame |
| idle_level | input | 1 | Level driven on data-out when idle or forced |
| force_out | input | 1 | Holds data-out at idle_level |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 32 | Transmit word |
| tx_ready | output | 1 | Holding stage can take a word |
| rx_valid | output | 1 | Received word pulse |
| rx_data | output | 32 | Received word |
| busy | output | 1 | Word held or frame in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| din_sync | output | 1 | Synchronised copy of miso |

## Verification
The hardest condition to create from the ports is the drain after `enable` is cleared. It needs a frame on the wire and a second word sitting in the holding stage at the moment the enable drops. The bench pushes one word, waits until the engine has taken it, pushes a second word, and then clears `enable`. It then counts exactly two received pulses and confirms that later offers are refused. Phase alignment is checked by a bench-side slave model that reacts to each observed `sclk` edge, across every combination of frame size, polarity and phase, with expected words and half-period lengths computed by arithmetic.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int WORD_W = 32;
  localparam int EDGE_W = 7;

  typedef enum logic [1:0] {
    FRM_8  = 2'b00,
    FRM_16 = 2'b01,
    FRM_32 = 2'b10,
    FRM_9  = 2'b11
  } frame_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } eng_state_e;

  function automatic logic [EDGE_W-1:0] frame_len(frame_e f);
    logic [EDGE_W-1:0] n;
    case (f)
      FRM_8:  n = EDGE_W'(8);
      FRM_16: n = EDGE_W'(16);
      FRM_32: n = EDGE_W'(32);
      FRM_9:  n = EDGE_W'(9);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  input  logic [1:0]          clk_sel,
  output logic                tick
);
  localparam int CW = PERIOD_W + 3;

  logic [CW-1:0]       cnt_q, cnt_d, half;
  logic [PERIOD_W-1:0] per_eff;
  logic [2:0]          mult;

  // half period = max(period,1) * {4,2,1,7}
  always_comb begin
    per_eff = (period == '0) ? PERIOD_W'(1) : period;
    case (clk_sel)
      2'b00:   mult = 3'd4;
      2'b01:   mult = 3'd2;
      2'b10:   mult = 3'd1;
      default: mult = 3'd7;
    endcase
    half = CW'(per_eff) * CW'(mult);
    tick = run && (cnt_q == half - CW'(1));
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: every frame starts counting its first half period from zero
  assert_cnt_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0))
    else $error("divider did not restart at frame start");

endmodule

// File: rtl/spi_din_sync.sv
module spi_din_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q_q, q_d;

  always_comb q_d = {q_q[STAGES-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign dout = q_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk2
      assert_din_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (dout == $past(din, 2)))
        else $error("synchronised input is not a two-cycle copy");
    end
  endgenerate

endmodule

// File: rtl/spi_tx_hold.sv
module spi_tx_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  input  logic         take,
  output logic         tx_ready,
  output logic         full,
  output logic [W-1:0] word
);
  logic         full_q, full_d;
  logic [W-1:0] word_q, word_d;
  logic         accept;

  always_comb begin
    tx_ready = enable && !full_q;
    accept   = tx_valid && tx_ready;
    full_d   = full_q;
    word_d   = word_q;
    if (accept) begin
      full_d = 1'b1;
      word_d = tx_data;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else begin
      full_q <= full_d;
      if (accept) word_q <= word_d;
    end
  end

  assign full = full_q;
  assign word = word_q;

  // R9: a word only enters while enabled and offered
  assert_accept_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(tx_valid && enable))
    else $error("holding stage filled without an enabled offer");

  // R10: the engine only takes a word that is present
  assert_take_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q)
    else $error("take while holding stage empty");

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_eng_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_full,
  input  logic [W-1:0] hold_word,
  output logic         take,
  input  logic         tick,
  output logic         run,
  input  logic         cpol,
  input  logic         cpha,
  input  logic [1:0]   word_mode,
  input  logic         nine_first,
  input  logic         idle_level,
  input  logic         force_out,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         rx_valid,
  output logic [W-1:0] rx_data
);
  eng_state_e        st_q, st_d;
  logic [EDGE_W-1:0] edge_q, edge_d, last_edge;
  logic              lvl_q, lvl_d, out_q, out_d;
  logic              pha_q, pha_d, pol_q, pol_d;
  logic [W-1:0]      sh_q, sh_d, rxs_q, rxs_d, rxd_q, rxd_d, loaded, merged;
  logic              rxv_q, rxv_d;
  frame_e            mode_q, mode_d, mode_in;
  logic              shift_now;

  always_comb begin
    mode_in = frame_e'(word_mode);
    case (mode_in)
      FRM_8:  loaded = {hold_word[7:0], {(W-8){1'b0}}};
      FRM_16: loaded = {hold_word[15:0], {(W-16){1'b0}}};
      FRM_32: loaded = hold_word;
      FRM_9:  loaded = {nine_first, hold_word[7:0], {(W-9){1'b0}}};
    endcase
    case (mode_q)
      FRM_8, FRM_9: merged = {rxd_q[W-1:8], rxs_q[7:0]};
      FRM_16:       merged = {rxd_q[W-1:16], rxs_q[15:0]};
      FRM_32:       merged = rxs_q;
    endcase
    last_edge = EDGE_W'({frame_len(mode_q), 1'b0});
    shift_now = edge_q[0] ^ pha_q;
  end

  // next state
  always_comb begin
    st_d   = st_q;   edge_d = edge_q; lvl_d  = lvl_q;  out_d = out_q;
    pha_d  = pha_q;  pol_d  = pol_q;  sh_d   = sh_q;   rxs_d = rxs_q;
    rxd_d  = rxd_q;  mode_d = mode_q; rxv_d  = 1'b0;   take  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (hold_full) begin
          take   = 1'b1;
          st_d   = ST_XFER;
          edge_d = '0;
          lvl_d  = 1'b0;
          mode_d = mode_in;
          pha_d  = cpha;
          pol_d  = cpol;
          rxs_d  = '0;
          if (!cpha) begin
            out_d = loaded[W-1];
            sh_d  = {loaded[W-2:0], 1'b0};
          end else begin
            out_d = idle_level;
            sh_d  = loaded;
          end
        end
      end
      ST_XFER: begin
        if (tick) begin
          if (edge_q == last_edge) begin
            st_d  = ST_IDLE;
            rxv_d = 1'b1;
            rxd_d = merged;
          end else begin
            lvl_d  = ~lvl_q;
            edge_d = edge_q + EDGE_W'(1);
            if (shift_now) begin
              out_d = sh_q[W-1];
              sh_d  = {sh_q[W-2:0], 1'b0};
            end else begin
              rxs_d = {rxs_q[W-2:0], miso};
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE; edge_q <= '0;   lvl_q <= 1'b0; out_q <= 1'b0;
      pha_q  <= 1'b0;    pol_q  <= 1'b0; sh_q  <= '0;   rxs_q <= '0;
      rxd_q  <= '0;      mode_q <= FRM_8; rxv_q <= 1'b0;
    end else begin
      st_q   <= st_d;    edge_q <= edge_d; lvl_q <= lvl_d; out_q <= out_d;
      pha_q  <= pha_d;   pol_q  <= pol_d;  sh_q  <= sh_d;  rxs_q <= rxs_d;
      rxd_q  <= rxd_d;   mode_q <= mode_d; rxv_q <= rxv_d;
    end
  end

  assign run      = (st_q == ST_XFER);
  assign sclk     = run ? (pol_q ^ lvl_q) : cpol;
  assign mosi     = (force_out || !run) ? idle_level : out_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |=> !rxv_q)
    else $error("done pulse longer than one cycle");

  assert_edge_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (edge_q <= last_edge))
    else $error("edge count beyond frame length");

  assert_sclk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(sclk))
    else $error("serial clock moved between divider ticks");

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int PERIOD_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                cpol,
  input  logic                cpha,
  input  logic [1:0]          clk_sel,
  input  logic [PERIOD_W-1:0] period,
  input  logic [1:0]          word_mode,
  input  logic                nine_first,
  input  logic                idle_level,
  input  logic                force_out,
  input  logic                tx_valid,
  input  logic [WORD_W-1:0]   tx_data,
  output logic                tx_ready,
  output logic                rx_valid,
  output logic [WORD_W-1:0]   rx_data,
  output logic                busy,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic                din_sync
);
  logic [1:0]        rst_q;
  logic              rst_s;
  logic              hold_full, take, tick, run;
  logic [WORD_W-1:0] hold_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  spi_tx_hold #(.W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_s), .enable(enable), .tx_valid(tx_valid),
    .tx_data(tx_data), .take(take), .tx_ready(tx_ready),
    .full(hold_full), .word(hold_word)
  );

  spi_clk_div #(.PERIOD_W(PERIOD_W)) u_div (
    .clk(clk), .rst_n(rst_s), .run(run), .period(period),
    .clk_sel(clk_sel), .tick(tick)
  );

  spi_shift_core #(.W(WORD_W)) u_core (
    .clk(clk), .rst_n(rst_s), .hold_full(hold_full), .hold_word(hold_word),
    .take(take), .tick(tick), .run(run), .cpol(cpol), .cpha(cpha),
    .word_mode(word_mode), .nine_first(nine_first), .idle_level(idle_level),
    .force_out(force_out), .miso(miso), .sclk(sclk), .mosi(mosi),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  spi_din_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s), .din(miso), .dout(din_sync)
  );

  assign busy = run | hold_full;

  // R9: once drained with enable low, the engine stays stopped
  assert_stay_stopped_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (!enable && !busy) |=> !busy)
    else $error("engine restarted while disabled");

endmodule

// File: tb/spi_master_engine_bench.sv
module spi_master_engine_bench;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable, cpol, cpha, nine_first, idle_level, force_out;
  logic [1:0]    clk_sel, word_mode;
  logic [PW-1:0] period;
  logic          tx_valid, tx_ready, rx_valid, busy, sclk, mosi, miso, din_sync;
  logic [31:0]   tx_data, rx_data;

  spi_master_engine #(.PERIOD_W(PW)) u_spi_master_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
    .clk_sel(clk_sel), .period(period), .word_mode(word_mode),
    .nine_first(nine_first), .idle_level(idle_level), .force_out(force_out),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .sclk(sclk),
    .mosi(mosi), .miso(miso), .din_sync(din_sync)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_rx = '0;

  // bench-side slave model
  bit          slv_on = 0, force_chk = 0, prev_sclk = 0, lead;
  int          slv_n, slv_idx, cap_n, edges, t_first, t_second, force_bad, cyc = 0;
  logic [31:0] slv_word, cap;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (force_chk && mosi !== idle_level) force_bad++;
    if (slv_on && sclk !== prev_sclk) begin
      lead = (prev_sclk == cpol);
      edges++;
      if (edges == 1) t_first = cyc;
      else if (edges == 2) t_second = cyc;
      if (lead == !cpha) begin
        cap = {cap[30:0], mosi};
        cap_n++;
      end else if (slv_idx < slv_n) begin
        miso = slv_word[slv_n-1-slv_idx];
        slv_idx++;
      end
    end
    prev_sclk = sclk;
  end

  function automatic int nbits(input logic [1:0] m);
    case (m)
      2'b00: return 8;
      2'b01: return 16;
      2'b10: return 32;
      default: return 9;
    endcase
  endfunction

  function automatic int half_of(input logic [1:0] sel, input int per);
    int p = (per == 0) ? 1 : per;
    case (sel)
      2'b00: return p * 4;
      2'b01: return p * 2;
      2'b10: return p;
      default: return p * 7;
    endcase
  endfunction

  task automatic do_frame(input logic [1:0] m, input bit pol, input bit pha,
                          input logic [1:0] sel, input int per,
                          input logic [31:0] tx, input logic [31:0] s,
                          input bit nine, input bit lvl, input bit frc);
    int n, w;
    logic [63:0] mask, exp_tx;
    @(negedge clk);
    word_mode = m; cpol = pol; cpha = pha; clk_sel = sel; period = PW'(per);
    nine_first = nine; idle_level = lvl; force_out = frc;
    n = nbits(m);
    @(negedge clk);
    chk(sclk == pol, "R4", "idle sclk before frame", {31'b0, sclk}, {31'b0, pol});
    chk(mosi == lvl, "R6", "idle mosi before frame", {31'b0, mosi}, {31'b0, lvl});
    slv_n = n; slv_word = s; cap = '0; cap_n = 0; edges = 0;
    prev_sclk = sclk; force_bad = 0;
    if (!pha) begin miso = s[n-1]; slv_idx = 1; end
    else slv_idx = 0;
    slv_on = 1; force_chk = frc;
    tx_data = tx; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(busy == 1'b1, "R10", "busy after accept", {31'b0, busy}, 32'd1);
    w = 0;
    while (!rx_valid && w < 6000) begin @(negedge clk); w++; end
    chk(rx_valid == 1'b1, "R10", "frame completion", {31'b0, rx_valid}, 32'd1);
    slv_on = 0; force_chk = 0;
    case (m)
      2'b00: exp_rx[7:0] = s[7:0];
      2'b01: exp_rx[15:0] = s[15:0];
      2'b10: exp_rx = s;
      default: exp_rx[7:0] = s[7:0];
    endcase
    chk(rx_data == exp_rx, "R8", "received word", rx_data, exp_rx);
    chk(cap_n == n, "R1", "bits sampled by slave", 32'(cap_n), 32'(n));
    if (!frc) begin
      mask = (64'd1 << n) - 64'd1;
      case (m)
        2'b00: exp_tx = {56'b0, tx[7:0]};
        2'b01: exp_tx = {48'b0, tx[15:0]};
        2'b10: exp_tx = {32'b0, tx};
        default: exp_tx = {55'b0, nine, tx[7:0]};
      endcase
      chk(({32'b0, cap} & mask) == exp_tx, (m == 2'b11) ? "R2" : "R1",
          "mosi bit sequence", cap, exp_tx[31:0]);
    end else begin
      chk(force_bad == 0, "R6", "forced mosi during frame", 32'(force_bad), 32'd0);
    end
    chk((t_second - t_first) == half_of(sel, per), (per == 0) ? "R11" : "R3",
        "half period", 32'(t_second - t_first), 32'(half_of(sel, per)));
    @(negedge clk);
    chk(rx_valid == 1'b0, "R10", "done pulse width", {31'b0, rx_valid}, 32'd0);
    chk(busy == 1'b0, "R10", "busy after frame", {31'b0, busy}, 32'd0);
    chk(sclk == pol, "R4", "idle sclk after frame", {31'b0, sclk}, {31'b0, pol});
    chk(mosi == lvl, "R6", "idle mosi after frame", {31'b0, mosi}, {31'b0, lvl});
  endtask

  task automatic drain_test();
    int pulses, w;
    @(negedge clk);
    word_mode = 2'b00; cpol = 0; cpha = 0; clk_sel = 2'b10; period = PW'(1);
    force_out = 0; idle_level = 0; miso = 1'b1; enable = 1'b1;
    tx_data = 32'h0000_0011; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    pulses = 0;
    tx_data = 32'h0000_0022; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0; enable = 1'b0;
    chk(tx_ready == 1'b0, "R9", "ready with enable low", {31'b0, tx_ready}, 32'd0);
    chk(busy == 1'b1, "R9", "busy while draining", {31'b0, busy}, 32'd1);
    w = 0;
    while (w < 200) begin
      @(negedge clk);
      if (rx_valid) pulses++;
      w++;
    end
    chk(pulses == 2, "R9", "frames sent after disable", 32'(pulses), 32'd2);
    chk(busy == 1'b0, "R9", "stopped after drain", {31'b0, busy}, 32'd0);
    exp_rx[7:0] = 8'hFF;
    chk(rx_data == exp_rx, "R8", "drained frame data", rx_data, exp_rx);
    tx_valid = 1'b1; tx_data = 32'h0000_0033;
    repeat (5) @(negedge clk);
    chk(tx_ready == 1'b0, "R9", "offer refused while disabled", {31'b0, tx_ready}, 32'd0);
    chk(busy == 1'b0, "R9", "no restart while disabled", {31'b0, busy}, 32'd0);
    tx_valid = 1'b0; enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic sync_test();
    @(negedge clk); miso = 1'b0;
    repeat (3) @(negedge clk);
    miso = 1'b1;
    @(negedge clk);
    chk(din_sync == 1'b0, "R7", "one edge after rise", {31'b0, din_sync}, 32'd0);
    @(negedge clk);
    chk(din_sync == 1'b1, "R7", "two edges after rise", {31'b0, din_sync}, 32'd1);
    miso = 1'b0;
    @(negedge clk);
    chk(din_sync == 1'b1, "R7", "one edge after fall", {31'b0, din_sync}, 32'd1);
    @(negedge clk);
    chk(din_sync == 1'b0, "R7", "two edges after fall", {31'b0, din_sync}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b1; cpol = 0; cpha = 0; clk_sel = 2'b00;
    period = PW'(1); word_mode = 2'b00; nine_first = 0; idle_level = 0;
    force_out = 0; tx_valid = 0; tx_data = '0; miso = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rx_data == 32'd0, "R8", "reset rx_data", rx_data, 32'd0);
    chk(rx_valid == 1'b0, "R10", "reset rx_valid", {31'b0, rx_valid}, 32'd0);
    chk(busy == 1'b0, "R10", "reset busy", {31'b0, busy}, 32'd0);
    chk(tx_ready == 1'b1, "R9", "reset tx_ready", {31'b0, tx_ready}, 32'd1);
    chk(sclk == 1'b0, "R4", "reset sclk", {31'b0, sclk}, 32'd0);
    chk(mosi == 1'b0, "R6", "reset mosi", {31'b0, mosi}, 32'd0);

    sync_test();

    // every frame size x polarity x phase
    for (int i = 0; i < 16; i++) begin
      logic [31:0] tx, s;
      tx = 32'hA5C3_0F96 ^ (32'(i) * 32'h1357_9BDF);
      s  = {tx[15:0], ~tx[31:16]} ^ 32'h3C3C_5A5A;
      do_frame(2'(i >> 2), i[1], i[0], 2'(i), i % 3, tx, s, i[0] ^ i[2], i[1] ^ i[3], 1'b0);
    end

    // divider sweep
    for (int sel = 0; sel < 4; sel++) begin
      for (int per = 0; per < 4; per++) begin
        do_frame(2'b00, 1'b0, 1'b0, 2'(sel), per, 32'(8'h5A + per), 32'(8'hC3 ^ sel),
                 1'b0, 1'b0, 1'b0);
      end
    end

    // forced data-out during frames at both levels
    do_frame(2'b01, 1'b1, 1'b0, 2'b10, 2, 32'h0000_0F0F, 32'h0000_1234, 1'b0, 1'b1, 1'b1);
    do_frame(2'b11, 1'b0, 1'b1, 2'b01, 1, 32'h0000_00FF, 32'h0000_0155, 1'b1, 1'b0, 1'b1);

    drain_test();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule